// File: doc/BRIEF.md
# MII Transmit Frame Sequencer

This block turns a byte-wide frame handed over by a host into the nibble stream an MII PHY expects. Once a frame is accepted it drives the transmit-enable line and the 4-bit data lines with a preamble, a start-of-frame delimiter, the payload (low nibble of each byte first), optional zero padding up to a minimum length and an optional 32-bit frame check sequence. After every frame, and after reset, it passes through a one-cycle defer state and a programmable inter-packet gap before it returns to idle and can accept another frame.

The host raises a start strobe for two clock cycles and presents the first byte with it. The sequencer pulses a byte-taken output while it sends the low nibble of each byte. The host then presents the following byte, together with an end marker on the final byte. Padding and checksum insertion are each enabled when a configuration-register bit or a per-frame descriptor bit is set. The two enables and the minimum length are captured when the frame is accepted. The collision-related states (jam, jam hold, backoff) keep their encodings but are never entered.

Top module: `mii_tx_sequencer`

## Requirements
- R1: After reset the sequencer spends one cycle in defer and then IPG_NIBBLES cycles in the gap state, with tx_en low throughout. It reaches idle on the edge after that, and a start strobe that is seen before then is ignored.
- R2: A start strobe sampled in idle moves the sequencer to the preamble on that edge. In the next cycle tx_en goes high, and txd carries seven nibbles of 0x5 followed by one nibble of 0xD. The second cycle of the strobe does not restart the frame.
- R3: Each payload byte is sent over two cycles, bits [3:0] first and then bits [7:4]. byte_taken is high exactly in the low-nibble cycles. The next byte and its end marker are sampled on the last cycle of the high nibble. The byte presented with frm_end high is the last one sent.
- R4: Checksum insertion is on when cfg_crc or desc_crc is high, and padding is on when cfg_pad or desc_pad is high. Both, together with min_len, are captured on the edge that accepts the frame, so later changes to them do not affect that frame.
- R5: When the payload byte count is at least min_len, the frame continues with the checksum if insertion is on, and ends after the last payload nibble if it is off.
- R6: When the payload byte count is below min_len and padding is on, zero bytes (two 0x0 nibbles each) are sent until the byte count equals min_len. The checksum always follows, whatever the checksum enables say.
- R7: When the payload byte count is below min_len and padding is off, no padding is sent. The checksum follows only if insertion is on.
- R8: The checksum is the reflected CRC-32 with generator 0x04C11DB7 (right-shifting form 0xEDB88320), preset to all ones and complemented at the end. It is computed over the payload and pad bytes, and its eight nibbles are sent from bits [3:0] up to bits [31:28].
- R9: After the last nibble of a frame, tx_en stays low for one defer cycle plus IPG_NIBBLES gap cycles. A start strobe during that time is ignored.
- R10: Whenever tx_en is low, txd is 0x0 and byte_taken is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Nibble clock |
| rst | input | 1 | Synchronous active-high reset |
| frm_start | input | 1 | Start strobe, held for two cycles with the first byte |
| frm_end | input | 1 | Marks the byte on frm_byte as the last of the frame |
| frm_byte | input | 8 | Current payload byte from the host |
| byte_taken | output | 1 | High while the low nibble of the current byte is sent |
| min_len | input | LEN_W | Minimum frame length in bytes (payload plus pad) |
| cfg_pad | input | 1 | Register-level pad enable |
| desc_pad | input | 1 | Per-frame pad enable |
| cfg_crc | input | 1 | Register-level checksum enable |
| desc_crc | input | 1 | Per-frame checksum enable |
| tx_en | output | 1 | MII transmit enable |
| txd | output | 4 | MII transmit data nibble |

## Verification
The bench aims at the length boundaries: a payload exactly at min_len (a design that compares with the wrong sense would send one zero byte and a checksum), a payload one byte short (exactly one pad byte, then a checksum though both checksum bits are off), and a single-byte frame, where the end marker arrives with the strobe. It flips every enable and min_len to zero right after a frame is accepted, so a design that reads them live instead of capturing them would drop the padding and checksum. It also raises the start strobe in the gap after reset and in the gap after a frame; a design that left the gap early or accepted from the wrong state would start sending where the line must stay quiet. Each checksum nibble is compared against a byte-wise CRC, which catches wrong bit order, wrong nibble order and a missing complement.

// File: rtl/mtx_pkg.sv
package mtx_pkg;

    typedef enum logic [3:0] {
        S_IDLE     = 4'd0,
        S_PREAMBLE = 4'd1,
        S_NIB_LO   = 4'd2,
        S_NIB_HI   = 4'd3,
        S_ZEROFILL = 4'd4,
        S_FCS      = 4'd5,
        S_GAP      = 4'd6,
        S_JAM      = 4'd7,
        S_JAM_HOLD = 4'd8,
        S_BACKOFF  = 4'd9,
        S_DEFER    = 4'd10
    } tx_state_e;

    typedef struct packed {
        logic pad_on;
        logic crc_on;
    } frame_opts_t;

    localparam int          CRC_W         = 32;
    localparam int          FCS_NIBBLES   = CRC_W / 4;
    localparam logic [3:0]  PRE_NIB       = 4'h5;
    localparam logic [3:0]  SFD_NIB       = 4'hD;
    localparam logic [CRC_W-1:0] CRC_POLY_REFL = 32'hEDB88320;
    localparam logic [CRC_W-1:0] CRC_PRESET    = '1;

    // Advance a right-shifting CRC-32 by four data bits, bit 0 first.
    function automatic logic [CRC_W-1:0] crc32_nibble(
        input logic [CRC_W-1:0] crc_in,
        input logic [3:0]       nib
    );
        logic [CRC_W-1:0] c;
        c = crc_in;
        for (int b = 0; b < 4; b++) begin
            if (c[0] ^ nib[b]) c = (c >> 1) ^ CRC_POLY_REFL;
            else               c = c >> 1;
        end
        return c;
    endfunction

endpackage

// File: rtl/mtx_crc32.sv
module mtx_crc32
    import mtx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             step,
    input  logic [3:0]       nib,
    output logic [CRC_W-1:0] fcs
);

    logic [CRC_W-1:0] crc_q;

    always_ff @(posedge clk) begin
        if (rst || clear) crc_q <= CRC_PRESET;
        else if (step)    crc_q <= crc32_nibble(crc_q, nib);
    end

    assign fcs = ~crc_q;

endmodule

// File: rtl/mtx_ctrl.sv
module mtx_ctrl
    import mtx_pkg::*;
#(
    parameter int LEN_W       = 16,
    parameter int PRE_NIBBLES = 7,
    parameter int IPG_NIBBLES = 24,
    parameter int IDX_W       = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frm_start,
    input  logic             frm_end,
    input  logic [7:0]       frm_byte,
    input  frame_opts_t      opts_in,
    input  logic [LEN_W-1:0] min_len,
    output tx_state_e        state,
    output logic [IDX_W-1:0] idx,
    output logic [7:0]       cur_byte,
    output logic             byte_taken
);

    localparam int GAP_W = $clog2(IPG_NIBBLES + 1);
    localparam logic [IDX_W-1:0] SFD_IDX  = IDX_W'(PRE_NIBBLES);
    localparam logic [IDX_W-1:0] FCS_LAST = IDX_W'(FCS_NIBBLES - 1);
    localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(IPG_NIBBLES - 1);

    logic [GAP_W-1:0] gap_cnt;
    logic             cur_last;
    logic             pad_hi;
    frame_opts_t      opts_q;
    logic [LEN_W-1:0] min_q;
    logic [LEN_W-1:0] byte_cnt;
    logic [LEN_W-1:0] sent_cnt;

    assign sent_cnt   = byte_cnt + LEN_W'(1);
    assign byte_taken = (state == S_NIB_LO);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= S_DEFER;
            idx      <= '0;
            gap_cnt  <= '0;
            cur_byte <= '0;
            cur_last <= 1'b0;
            pad_hi   <= 1'b0;
            opts_q   <= '0;
            min_q    <= '0;
            byte_cnt <= '0;
        end else begin
            case (state)
                S_IDLE: begin
                    if (frm_start) begin
                        state    <= S_PREAMBLE;
                        idx      <= '0;
                        cur_byte <= frm_byte;
                        cur_last <= frm_end;
                        opts_q   <= opts_in;
                        min_q    <= min_len;
                        byte_cnt <= '0;
                    end
                end
                S_PREAMBLE: begin
                    if (idx == SFD_IDX) begin
                        state <= S_NIB_LO;
                        idx   <= '0;
                    end else begin
                        idx <= idx + IDX_W'(1);
                    end
                end
                S_NIB_LO: state <= S_NIB_HI;
                S_NIB_HI: begin
                    byte_cnt <= sent_cnt;
                    idx      <= '0;
                    pad_hi   <= 1'b0;
                    if (!cur_last) begin
                        cur_byte <= frm_byte;
                        cur_last <= frm_end;
                        state    <= S_NIB_LO;
                    end else if (sent_cnt < min_q && opts_q.pad_on) begin
                        state <= S_ZEROFILL;
                    end else if (opts_q.crc_on) begin
                        state <= S_FCS;
                    end else begin
                        state <= S_DEFER;
                    end
                end
                S_ZEROFILL: begin
                    pad_hi <= ~pad_hi;
                    if (pad_hi) begin
                        byte_cnt <= sent_cnt;
                        if (sent_cnt >= min_q) begin
                            state <= S_FCS;
                            idx   <= '0;
                        end
                    end
                end
                S_FCS: begin
                    if (idx == FCS_LAST) state <= S_DEFER;
                    idx <= idx + IDX_W'(1);
                end
                S_DEFER: begin
                    state   <= S_GAP;
                    gap_cnt <= '0;
                end
                S_GAP: begin
                    if (gap_cnt == GAP_LAST) state <= S_IDLE;
                    gap_cnt <= gap_cnt + GAP_W'(1);
                end
                default: state <= S_DEFER;
            endcase
        end
    end

    // R1
    defer_to_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (state == S_DEFER) |=> (state == S_GAP));

    // R9
    gap_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (state == S_GAP) |=> (state == S_GAP || state == S_IDLE));

    // R2
    accept_chk: assert property (@(posedge clk) disable iff (rst)
        (state == S_IDLE && frm_start) |=>
            (state == S_PREAMBLE && cur_byte == $past(frm_byte)));

    // R6
    zerofill_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (state == S_ZEROFILL) |=> (state == S_ZEROFILL || state == S_FCS));

endmodule

// File: rtl/mtx_txmux.sv
module mtx_txmux
    import mtx_pkg::*;
#(
    parameter int PRE_NIBBLES = 7,
    parameter int IDX_W       = 3
) (
    input  tx_state_e        state,
    input  logic [IDX_W-1:0] idx,
    input  logic [7:0]       cur_byte,
    input  logic [CRC_W-1:0] fcs,
    output logic             tx_en,
    output logic [3:0]       txd,
    output logic             crc_step
);

    localparam logic [IDX_W-1:0] SFD_IDX = IDX_W'(PRE_NIBBLES);

    always_comb begin
        tx_en    = 1'b1;
        txd      = 4'h0;
        crc_step = 1'b0;
        case (state)
            S_PREAMBLE: txd = (idx == SFD_IDX) ? SFD_NIB : PRE_NIB;
            S_NIB_LO: begin
                txd      = cur_byte[3:0];
                crc_step = 1'b1;
            end
            S_NIB_HI: begin
                txd      = cur_byte[7:4];
                crc_step = 1'b1;
            end
            S_ZEROFILL: crc_step = 1'b1;
            S_FCS:      txd = fcs[{idx, 2'b00} +: 4];
            default:    tx_en = 1'b0;
        endcase
    end

endmodule

// File: rtl/mii_tx_sequencer.sv
module mii_tx_sequencer
    import mtx_pkg::*;
#(
    parameter int LEN_W       = 16,
    parameter int PRE_NIBBLES = 7,
    parameter int IPG_NIBBLES = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frm_start,
    input  logic             frm_end,
    input  logic [7:0]       frm_byte,
    output logic             byte_taken,
    input  logic [LEN_W-1:0] min_len,
    input  logic             cfg_pad,
    input  logic             desc_pad,
    input  logic             cfg_crc,
    input  logic             desc_crc,
    output logic             tx_en,
    output logic [3:0]       txd
);

    localparam int PRE_IDX_W = $clog2(PRE_NIBBLES + 1);
    localparam int FCS_IDX_W = $clog2(FCS_NIBBLES);
    localparam int IDX_W     = (PRE_IDX_W > FCS_IDX_W) ? PRE_IDX_W : FCS_IDX_W;

    tx_state_e        state;
    logic [IDX_W-1:0] idx;
    logic [7:0]       cur_byte;
    logic [CRC_W-1:0] fcs;
    logic             crc_step;
    frame_opts_t      opts;

    assign opts.pad_on = cfg_pad | desc_pad;
    assign opts.crc_on = cfg_crc | desc_crc;

    mtx_ctrl #(
        .LEN_W       (LEN_W),
        .PRE_NIBBLES (PRE_NIBBLES),
        .IPG_NIBBLES (IPG_NIBBLES),
        .IDX_W       (IDX_W)
    ) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .frm_start  (frm_start),
        .frm_end    (frm_end),
        .frm_byte   (frm_byte),
        .opts_in    (opts),
        .min_len    (min_len),
        .state      (state),
        .idx        (idx),
        .cur_byte   (cur_byte),
        .byte_taken (byte_taken)
    );

    mtx_txmux #(
        .PRE_NIBBLES (PRE_NIBBLES),
        .IDX_W       (IDX_W)
    ) u_mux (
        .state    (state),
        .idx      (idx),
        .cur_byte (cur_byte),
        .fcs      (fcs),
        .tx_en    (tx_en),
        .txd      (txd),
        .crc_step (crc_step)
    );

    mtx_crc32 u_crc (
        .clk   (clk),
        .rst   (rst),
        .clear (state == S_PREAMBLE),
        .step  (crc_step),
        .nib   (txd),
        .fcs   (fcs)
    );

    // R10
    take_en_chk: assert property (@(posedge clk) disable iff (rst)
        byte_taken |-> tx_en);

    // R8
    fcs_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state == S_FCS && $past(state) == S_FCS) |-> $stable(fcs));

endmodule

// File: tb/test_mii_tx_sequencer.sv
module test_mii_tx_sequencer;

    localparam int CLK_PERIOD = 10;
    localparam int GAP_N      = 24;
    localparam int LEN_W      = 16;
    localparam int WATCHDOG   = 150000;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             frm_start = 1'b0;
    logic             frm_end = 1'b0;
    logic [7:0]       frm_byte = 8'h00;
    logic             byte_taken;
    logic [LEN_W-1:0] min_len = '0;
    logic             cfg_pad = 1'b0, desc_pad = 1'b0, cfg_crc = 1'b0, desc_crc = 1'b0;
    logic             tx_en;
    logic [3:0]       txd;

    always #(CLK_PERIOD/2) clk = ~clk;

    mii_tx_sequencer #(
        .LEN_W       (LEN_W),
        .PRE_NIBBLES (7),
        .IPG_NIBBLES (GAP_N)
    ) i_mii_tx_sequencer (
        .clk        (clk),
        .rst        (rst),
        .frm_start  (frm_start),
        .frm_end    (frm_end),
        .frm_byte   (frm_byte),
        .byte_taken (byte_taken),
        .min_len    (min_len),
        .cfg_pad    (cfg_pad),
        .desc_pad   (desc_pad),
        .cfg_crc    (cfg_crc),
        .desc_crc   (desc_crc),
        .tx_en      (tx_en),
        .txd        (txd)
    );

    // Reference model state: expected {byte_taken, txd} per active cycle.
    logic [4:0]  exp_q[$];
    string       tag_q[$];
    int          gap_left = 0;
    string       quiet_tag = "R1/R10";
    string       path_tag = "R5";
    logic [7:0]  host_bytes[$];
    int          host_idx = 0;
    bit          host_on = 1'b0;
    int          vectors = 0;
    int          fails = 0;
    int          cycles = 0;

    task automatic push_nib(input logic take, input logic [3:0] n, input string t);
        exp_q.push_back({take, n});
        tag_q.push_back(t);
    endtask

    // Built from the requirements when the model accepts a start strobe.
    task automatic build_frame();
        bit          pad_on, crc_on;
        int          len;
        logic [31:0] c;
        logic [7:0]  data[$];
        pad_on = cfg_pad | desc_pad;
        crc_on = cfg_crc | desc_crc;
        for (int i = 0; i < 7; i++) push_nib(1'b0, 4'h5, "R2");
        push_nib(1'b0, 4'hD, "R2");
        foreach (host_bytes[k]) begin
            push_nib(1'b1, host_bytes[k][3:0], "R3");
            push_nib(1'b0, host_bytes[k][7:4], "R3");
            data.push_back(host_bytes[k]);
        end
        len = host_bytes.size();
        if (len < int'(min_len) && pad_on) begin
            while (len < int'(min_len)) begin
                push_nib(1'b0, 4'h0, "R6");
                push_nib(1'b0, 4'h0, "R6");
                data.push_back(8'h00);
                len++;
            end
            crc_on = 1'b1;
        end
        if (crc_on) begin
            c = 32'hFFFFFFFF;
            foreach (data[k]) begin
                c = c ^ {24'h0, data[k]};
                for (int b = 0; b < 8; b++)
                    c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
            end
            c = ~c;
            for (int i = 0; i < 8; i++) push_nib(1'b0, c[4*i +: 4], {path_tag, "/R8"});
        end
    endtask

    task automatic tick();
        logic       e_en, e_take;
        logic [3:0] e_d;
        string      t;
        @(posedge clk);
        cycles++;
        if (rst) begin
            exp_q.delete();
            tag_q.delete();
            gap_left = 1 + GAP_N;
        end else if (exp_q.size() > 0) begin
            void'(exp_q.pop_front());
            void'(tag_q.pop_front());
            if (exp_q.size() == 0) gap_left = 1 + GAP_N;
        end else if (gap_left > 0) begin
            gap_left--;
        end else if (frm_start) begin
            build_frame();
        end
        @(negedge clk);
        e_en   = (exp_q.size() > 0);
        e_d    = e_en ? exp_q[0][3:0] : 4'h0;
        e_take = e_en ? exp_q[0][4] : 1'b0;
        t      = e_en ? tag_q[0] : quiet_tag;
        vectors++;
        if (tx_en !== e_en || txd !== e_d || byte_taken !== e_take) begin
            fails++;
            $display("FAIL %s cycle %0d: tx_en/txd/byte_taken got %b/%h/%b expected %b/%h/%b",
                     t, cycles, tx_en, txd, byte_taken, e_en, e_d, e_take);
        end
        if (host_on && byte_taken) begin
            host_idx++;
            if (host_idx < host_bytes.size()) begin
                frm_byte = host_bytes[host_idx];
                frm_end  = (host_idx == host_bytes.size() - 1);
            end
        end
        if (cycles > WATCHDOG) begin
            fails++;
            $display("FAIL R9 watchdog expired after %0d cycles, expected completion", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    endtask

    task automatic wait_idle();
        while (!(exp_q.size() == 0 && gap_left == 0)) tick();
    endtask

    task automatic send_frame(input int n, input int seed, input logic [LEN_W-1:0] mn,
                              input bit cp, input bit dp, input bit cc, input bit dc,
                              input string ptag, input bit flip);
        wait_idle();
        host_bytes.delete();
        for (int i = 0; i < n; i++) host_bytes.push_back(8'((seed * 37 + i * 13 + 5) & 255));
        path_tag  = ptag;
        quiet_tag = {ptag, "/R9/R10"};
        min_len   = mn;
        cfg_pad   = cp;
        desc_pad  = dp;
        cfg_crc   = cc;
        desc_crc  = dc;
        host_idx  = 0;
        host_on   = 1'b1;
        frm_byte  = host_bytes[0];
        frm_end   = (n == 1);
        frm_start = 1'b1;
        tick();
        tick();
        frm_start = 1'b0;
        if (flip) begin
            // R4: enables and length must have been captured at acceptance
            cfg_pad = 1'b0; desc_pad = 1'b0; cfg_crc = 1'b0; desc_crc = 1'b0;
            min_len = '0;
        end
        while (exp_q.size() > 0) tick();
        host_on = 1'b0;
    endtask

    initial begin
        // R1: reset state, then a strobe inside the start-up gap is ignored
        rst = 1'b1;
        repeat (3) tick();
        rst = 1'b0;
        repeat (2) tick();
        frm_byte  = 8'hA5;
        frm_start = 1'b1;
        tick();
        tick();
        frm_start = 1'b0;
        wait_idle();
        repeat (3) tick();

        // R5: long frame, checksum via register bit
        send_frame(64, 1, 16'd60, 1'b0, 1'b0, 1'b1, 1'b0, "R5", 1'b0);
        // R5: long frame, no checksum
        send_frame(70, 2, 16'd60, 1'b0, 1'b0, 1'b0, 1'b0, "R5", 1'b0);
        // R6: short frame padded via descriptor, checksum forced
        send_frame(10, 3, 16'd20, 1'b0, 1'b1, 1'b0, 1'b0, "R6", 1'b0);
        // R6: one byte short, exactly one pad byte
        send_frame(19, 4, 16'd20, 1'b1, 1'b0, 1'b0, 1'b0, "R6", 1'b0);
        // R7: short, no pad, checksum via descriptor
        send_frame(12, 5, 16'd40, 1'b0, 1'b0, 1'b0, 1'b1, "R7", 1'b0);
        // R7: short, no pad, no checksum
        send_frame(12, 6, 16'd40, 1'b0, 1'b0, 1'b0, 1'b0, "R7", 1'b0);
        // R5: length equal to minimum with pad on: no padding
        send_frame(20, 7, 16'd20, 1'b1, 1'b1, 1'b0, 1'b0, "R5", 1'b0);
        // R3: single-byte frame, end marker with the strobe
        send_frame(1, 8, 16'd0, 1'b0, 1'b0, 1'b1, 1'b0, "R3", 1'b0);
        // R4: inputs cleared right after acceptance
        send_frame(8, 9, 16'd16, 1'b1, 1'b0, 1'b1, 1'b0, "R4", 1'b1);
        // R4: descriptor checksum bit alone
        send_frame(30, 10, 16'd4, 1'b0, 1'b0, 1'b0, 1'b1, "R4", 1'b0);

        // R9: strobe inside the post-frame gap is ignored
        repeat (3) tick();
        frm_byte  = 8'h3C;
        frm_end   = 1'b1;
        frm_start = 1'b1;
        tick();
        tick();
        frm_start = 1'b0;
        wait_idle();
        repeat (5) tick();

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule